// File: doc/BRIEF.md
# High-Speed Receive Lane Controller

This block sequences the receive side of one serial lane that switches between a low-power signalling mode and a high-speed burst mode. It watches the decoded low-power line state and a raw high-speed activity strobe. From these it decides when to switch on the differential line termination and when high-speed transitions can be trusted. It also decides when they must be ignored again at the end of a burst and, on a clock lane, when the clock has stopped. The analog sampling, the deserialiser and the sync-word search are outside the block. The block only produces the three control outputs that gate them.

Each interval is a count of controller clock cycles held in a 16-bit configuration input. Software converts the nanosecond and unit-interval limits of the lane into these counts. The termination-enable count and the settle count both start at the first cycle in which the prepare state (LP-00) is seen, not at the first high-speed transition. A count of zero makes its phase complete on the next clock edge. A clock-lane build adds an inactivity timeout that drops the receive window and raises a loss flag. A data-lane build leaves that logic out.

Top module: `dphy_hs_rx_lane_ctrl`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `term_en`, `rx_valid` and `clk_lost` are 0, whatever `lp_state` carries during reset.
- R2: A burst starts only from the sequence LP-11, then LP-01, then LP-00, with `lp_state` encoded as 2'b11, 2'b01 and 2'b00. LP-00 straight after LP-11, the LP-10 state (2'b10) and LP-01 followed by LP-10 all leave the outputs at 0.
- R3: Count the clock edge that first samples LP-00 after LP-01 as edge 0. `term_en` rises at edge min(`cfg_term_cycles`, `cfg_settle_cycles`) + 1, so termination is never later than the receive window.
- R4: `rx_valid` rises at edge `cfg_settle_cycles` + 1, counted the same way as in R3.
- R5: When `burst_end` is sampled high while `rx_valid` is high, `rx_valid` is low after that edge (edge 0). `term_en` stays high and falls at edge `cfg_skip_cycles` + 1.
- R6: An edge that samples LP-11 in any state leaves `term_en`, `rx_valid` and `clk_lost` at 0 after that edge.
- R7: Clock lane (`IS_CLOCK_LANE`=1): while `rx_valid` is high, `cfg_miss_cycles` + 1 consecutive edges that sample `hs_activity` low raise `clk_lost` and drop `rx_valid` and `term_en` on the last of those edges. A shorter gap has no effect.
- R8: Data lane (`IS_CLOCK_LANE`=0): `clk_lost` stays 0, and `rx_valid` stays high through any gap in `hs_activity`.
- R9: After the skip window expires or a clock loss occurs, no new LP-01/LP-00 sequence raises `term_en` or `rx_valid` until LP-11 has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| lp_state | input | 2 | Decoded low-power line state {P, N}: 11, 01, 00, 10 |
| hs_activity | input | 1 | High in a cycle in which high-speed transitions were seen |
| burst_end | input | 1 | Pulse from the data path marking the end of burst payload |
| cfg_term_cycles | input | CNT_W | Cycles from prepare start to termination enable |
| cfg_settle_cycles | input | CNT_W | Cycles from prepare start to the receive window opening |
| cfg_skip_cycles | input | CNT_W | Cycles termination is held after burst end |
| cfg_miss_cycles | input | CNT_W | Allowed inactive cycles before clock loss (clock lane) |
| term_en | output | 1 | Line termination enable |
| rx_valid | output | 1 | High-speed transitions may be trusted |
| clk_lost | output | 1 | Clock lane stopped toggling during a burst |

## Verification
The bench builds two copies side by side and drives both with the same stimulus: `dut_i` as a clock lane and `dut_data_i` as a data lane, both with 16-bit counters. This makes the inactivity timeout and its absence visible in the same burst. Timing windows are kept to small random counts (0 to 30 cycles), so that many bursts fit in a short run. Zero counts, a settle count smaller than the termination count, LP-11 aborts in prepare and in burst, and gaps one cycle short of the timeout are driven as directed cases.

// File: rtl/dphy_rx_pkg.sv
package dphy_rx_pkg;

  typedef enum logic [2:0] {
    ST_STOP,   // LP-11 idle
    ST_REQ,    // LP-01 request seen
    ST_PREP,   // LP-00 prepare, timers running
    ST_HS,     // receive window open
    ST_SKIP,   // burst over, termination held
    ST_QUIET   // wait for LP-11
  } lane_st_t;

  localparam logic [1:0] LP_STOP = 2'b11;
  localparam logic [1:0] LP_REQ  = 2'b01;
  localparam logic [1:0] LP_PREP = 2'b00;
  localparam logic [1:0] LP_ESC  = 2'b10;

endpackage

// File: rtl/dphy_phase_timer.sv
module dphy_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] elapsed
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      elapsed <= '0;
    end else if (elapsed != SAT) begin
      elapsed <= elapsed + 1'b1;
    end
  end

endmodule

// File: rtl/dphy_activity_mon.sv
module dphy_activity_mon #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             watch,
  input  logic             hs_activity,
  input  logic [CNT_W-1:0] cfg_miss_cycles,
  output logic             timeout
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || !watch || hs_activity) begin
      gap <= '0;
    end else if (gap != SAT) begin
      gap <= gap + 1'b1;
    end
  end

  assign timeout = watch && !hs_activity && (gap >= cfg_miss_cycles);

endmodule

// File: rtl/dphy_lane_fsm.sv
module dphy_lane_fsm
  import dphy_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       lp_state,
  input  logic             burst_end,
  input  logic             clk_timeout,
  input  logic [CNT_W-1:0] prep_elapsed,
  input  logic [CNT_W-1:0] skip_elapsed,
  input  logic [CNT_W-1:0] cfg_term_cycles,
  input  logic [CNT_W-1:0] cfg_settle_cycles,
  input  logic [CNT_W-1:0] cfg_skip_cycles,
  output lane_st_t         state,
  output logic             term_en,
  output logic             rx_valid,
  output logic             clk_lost
);

  logic settle_due;
  logic term_due;
  logic skip_due;

  assign settle_due = prep_elapsed >= cfg_settle_cycles;
  assign term_due   = (prep_elapsed >= cfg_term_cycles) || settle_due;
  assign skip_due   = skip_elapsed >= cfg_skip_cycles;

  always_ff @(posedge clk) begin
    if (rst || lp_state == LP_STOP) begin
      state    <= ST_STOP;
      term_en  <= 1'b0;
      rx_valid <= 1'b0;
      clk_lost <= 1'b0;
    end else begin
      case (state)
        ST_STOP: begin
          if (lp_state == LP_REQ) state <= ST_REQ;
        end
        ST_REQ: begin
          if (lp_state == LP_PREP)     state <= ST_PREP;
          else if (lp_state != LP_REQ) state <= ST_STOP;
        end
        ST_PREP: begin
          if (term_due) term_en <= 1'b1;
          if (settle_due) begin
            state    <= ST_HS;
            rx_valid <= 1'b1;
          end
        end
        ST_HS: begin
          if (clk_timeout) begin
            state    <= ST_QUIET;
            rx_valid <= 1'b0;
            term_en  <= 1'b0;
            clk_lost <= 1'b1;
          end else if (burst_end) begin
            state    <= ST_SKIP;
            rx_valid <= 1'b0;
          end
        end
        ST_SKIP: begin
          if (skip_due) begin
            state   <= ST_QUIET;
            term_en <= 1'b0;
          end
        end
        default: begin
          state <= ST_QUIET;
        end
      endcase
    end
  end

endmodule

// File: rtl/dphy_hs_rx_lane_ctrl.sv
module dphy_hs_rx_lane_ctrl
  import dphy_rx_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter bit IS_CLOCK_LANE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       lp_state,
  input  logic             hs_activity,
  input  logic             burst_end,
  input  logic [CNT_W-1:0] cfg_term_cycles,
  input  logic [CNT_W-1:0] cfg_settle_cycles,
  input  logic [CNT_W-1:0] cfg_skip_cycles,
  input  logic [CNT_W-1:0] cfg_miss_cycles,
  output logic             term_en,
  output logic             rx_valid,
  output logic             clk_lost
);

  lane_st_t         state;
  logic [CNT_W-1:0] prep_elapsed;
  logic [CNT_W-1:0] skip_elapsed;
  logic             clk_timeout;

  dphy_phase_timer #(.CNT_W(CNT_W)) u_prep_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_PREP),
    .elapsed (prep_elapsed)
  );

  dphy_phase_timer #(.CNT_W(CNT_W)) u_skip_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_SKIP),
    .elapsed (skip_elapsed)
  );

  generate
    if (IS_CLOCK_LANE) begin : g_clk_mon
      dphy_activity_mon #(.CNT_W(CNT_W)) u_act_mon (
        .clk             (clk),
        .rst             (rst),
        .watch           (state == ST_HS),
        .hs_activity     (hs_activity),
        .cfg_miss_cycles (cfg_miss_cycles),
        .timeout         (clk_timeout)
      );
    end else begin : g_no_mon
      assign clk_timeout = 1'b0;
    end
  endgenerate

  dphy_lane_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk               (clk),
    .rst               (rst),
    .lp_state          (lp_state),
    .burst_end         (burst_end),
    .clk_timeout       (clk_timeout),
    .prep_elapsed      (prep_elapsed),
    .skip_elapsed      (skip_elapsed),
    .cfg_term_cycles   (cfg_term_cycles),
    .cfg_settle_cycles (cfg_settle_cycles),
    .cfg_skip_cycles   (cfg_skip_cycles),
    .state             (state),
    .term_en           (term_en),
    .rx_valid          (rx_valid),
    .clk_lost          (clk_lost)
  );

endmodule

// File: rtl/dphy_lane_ctrl_chk.sv
module dphy_lane_ctrl_chk #(
  parameter bit IS_CLOCK_LANE = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] lp_state,
  input logic       burst_end,
  input logic       term_en,
  input logic       rx_valid,
  input logic       clk_lost
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!term_en && !rx_valid && !clk_lost));

  p_valid_needs_term_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> term_en);

  p_valid_rise_not_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> ($past(lp_state) != 2'b11));

  p_burst_end_closes_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && burst_end && lp_state != 2'b11) |=> !rx_valid);

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (lp_state == 2'b11) |=> (!term_en && !rx_valid && !clk_lost));

  p_loss_quiets_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_lost) |-> (!rx_valid && !term_en));

  generate
    if (!IS_CLOCK_LANE) begin : g_data
      p_data_no_loss_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_lost);
    end
  endgenerate

endmodule

bind dphy_hs_rx_lane_ctrl dphy_lane_ctrl_chk #(.IS_CLOCK_LANE(IS_CLOCK_LANE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lp_state  (lp_state),
  .burst_end (burst_end),
  .term_en   (term_en),
  .rx_valid  (rx_valid),
  .clk_lost  (clk_lost)
);

// File: tb/dphy_hs_rx_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module dphy_hs_rx_lane_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  lp_state;
  logic        hs_activity;
  logic        burst_end;
  logic [15:0] cfg_term, cfg_settle, cfg_skip, cfg_miss;
  logic        term_c, valid_c, lost_c;
  logic        term_d, valid_d, lost_d;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dphy_hs_rx_lane_ctrl #(.CNT_W(16), .IS_CLOCK_LANE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .lp_state(lp_state), .hs_activity(hs_activity),
    .burst_end(burst_end), .cfg_term_cycles(cfg_term), .cfg_settle_cycles(cfg_settle),
    .cfg_skip_cycles(cfg_skip), .cfg_miss_cycles(cfg_miss),
    .term_en(term_c), .rx_valid(valid_c), .clk_lost(lost_c));

  dphy_hs_rx_lane_ctrl #(.CNT_W(16), .IS_CLOCK_LANE(1'b0)) dut_data_i (
    .clk(clk), .rst(rst), .lp_state(lp_state), .hs_activity(hs_activity),
    .burst_end(burst_end), .cfg_term_cycles(cfg_term), .cfg_settle_cycles(cfg_settle),
    .cfg_skip_cycles(cfg_skip), .cfg_miss_cycles(cfg_miss),
    .term_en(term_d), .rx_valid(valid_d), .clk_lost(lost_d));

  function automatic int exp_term_edge(int t, int s);
    return ((t < s) ? t : s) + 1;
  endfunction

  function automatic int exp_valid_edge(int s);
    return s + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Drive LP-01 then LP-00; returns just after the edge sampling LP-00.
  task automatic enter_prep;
    lp_state = 2'b01;
    tick();
    lp_state = 2'b00;
    tick();
  endtask

  task automatic run_prep(int t, int s, output int kt, output int kv);
    int lim;
    cfg_term = 16'(t);
    cfg_settle = 16'(s);
    hs_activity = 1'b1;
    kt = 0;
    kv = 0;
    enter_prep();
    lim = ((t > s) ? t : s) + 4;
    for (int k = 1; k <= lim; k++) begin
      tick();
      if (term_c && kt == 0) kt = k;
      if (valid_c && kv == 0) kv = k;
    end
  endtask

  task automatic finish_burst(int skip, string tag);
    int kf;
    cfg_skip = 16'(skip);
    burst_end = 1'b1;
    tick();
    burst_end = 1'b0;
    chk({tag, " R5 valid closes at burst end"}, valid_c, 0);
    chk({tag, " R5 termination held at burst end"}, term_c, 1);
    kf = 0;
    for (int k = 1; k <= skip + 3; k++) begin
      tick();
      if (!term_c && kf == 0) kf = k;
    end
    chk({tag, " R5 skip window edge"}, kf, skip + 1);
  endtask

  task automatic back_to_stop(string tag);
    lp_state = 2'b11;
    tick();
    chk({tag, " R6 stop clears outputs"}, {29'd0, term_c, valid_c, lost_c}, 0);
  endtask

  task automatic burst(int t, int s, int skip, string tag);
    int kt, kv;
    run_prep(t, s, kt, kv);
    chk({tag, " R3 termination edge"}, kt, exp_term_edge(t, s));
    chk({tag, " R4 valid edge"}, kv, exp_valid_edge(s));
    finish_burst(skip, tag);
    back_to_stop(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int kt, kv, seen, m;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    lp_state = 2'b11;
    hs_activity = 1'b0;
    burst_end = 1'b0;
    cfg_term = 16'd2;
    cfg_settle = 16'd4;
    cfg_skip = 16'd2;
    cfg_miss = 16'd5;
    @(negedge clk);
    tick();
    lp_state = 2'b01;
    tick();
    lp_state = 2'b00;
    ticks(8);
    chk("R1 outputs low in reset", {29'd0, term_c, valid_c, lost_c}, 0);
    lp_state = 2'b11;
    rst = 1'b0;
    tick();
    chk("R1 outputs low after reset", {29'd0, term_c, valid_c, lost_c}, 0);

    // R2: sequences that must not start a burst
    cfg_term = 16'd1;
    cfg_settle = 16'd2;
    lp_state = 2'b00;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      seen |= int'(term_c | valid_c);
    end
    chk("R2 LP-00 without request ignored", seen, 0);
    lp_state = 2'b11;
    tick();
    lp_state = 2'b10;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      seen |= int'(term_c | valid_c);
    end
    lp_state = 2'b00;
    for (int i = 0; i < 10; i++) begin
      tick();
      seen |= int'(term_c | valid_c);
    end
    chk("R2 LP-10 then LP-00 ignored", seen, 0);
    lp_state = 2'b11;
    tick();
    lp_state = 2'b01;
    tick();
    lp_state = 2'b10;
    tick();
    lp_state = 2'b00;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      seen |= int'(term_c | valid_c);
    end
    chk("R2 LP-01 LP-10 LP-00 ignored", seen, 0);
    lp_state = 2'b11;
    tick();

    // Directed timing corners
    burst(0, 0, 0, "zero counts");
    burst(20, 3, 5, "settle before term");
    burst(3, 12, 1, "term before settle");

    // R6 abort during prepare
    cfg_term = 16'd10;
    cfg_settle = 16'd20;
    enter_prep();
    ticks(3);
    lp_state = 2'b11;
    tick();
    chk("R6 abort in prepare", {30'd0, term_c, valid_c}, 0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      seen |= int'(term_c | valid_c);
    end
    chk("R6 stays idle after abort", seen, 0);

    // R6 abort during burst
    run_prep(2, 3, kt, kv);
    chk("R4 valid open before HS abort", valid_c, 1);
    back_to_stop("abort in burst");

    // R9 quiet after skip expiry
    run_prep(1, 2, kt, kv);
    finish_burst(2, "quiet");
    lp_state = 2'b01;
    tick();
    lp_state = 2'b00;
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      tick();
      seen |= int'(term_c | valid_c);
    end
    chk("R9 no re-entry before LP-11", seen, 0);
    back_to_stop("after quiet");

    // R7 / R8 clock loss, two timeout values
    for (int pass = 0; pass < 2; pass++) begin
      m = (pass == 0) ? 7 : 0;
      cfg_miss = 16'(m);
      run_prep(2, 4, kt, kv);
      if (m > 0) begin
        hs_activity = 1'b0;
        ticks(m);
        hs_activity = 1'b1;
        tick();
        chk("R7 short gap tolerated", {30'd0, lost_c, valid_c}, 1);
      end
      hs_activity = 1'b0;
      seen = 0;
      for (int k = 1; k <= m + 3; k++) begin
        tick();
        if (lost_c && seen == 0) begin
          seen = k;
          chk("R7 loss drops valid and term", {30'd0, valid_c, term_c}, 0);
        end
      end
      chk("R7 loss edge", seen, m + 1);
      chk("R8 data lane keeps valid", {30'd0, valid_d, lost_d}, 2);
      hs_activity = 1'b1;
      lp_state = 2'b01;
      tick();
      lp_state = 2'b00;
      ticks(10);
      chk("R9 no re-entry after loss", {30'd0, term_c, valid_c}, 0);
      back_to_stop("after loss");
      chk("R8 data lane stop", {30'd0, valid_d, lost_d}, 0);
    end
    cfg_miss = 16'd40;

    // Random bursts
    for (int it = 0; it < 30; it++) begin
      int t, s, sk;
      t = int'($urandom_range(0, 30));
      s = int'($urandom_range(0, 30));
      sk = int'($urandom_range(0, 30));
      burst(t, s, sk, "random");
      ticks(int'($urandom_range(0, 4)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule